// File: doc/BRIEF.md
# Compare-Driven Waveform Timer

This block is an up-counting timer whose count is compared against a set of per-channel compare values to produce one waveform per channel. A selectable prescaler decides how often the counter moves, and a two-bit mode input picks between a frequency mode and a single-slope PWM mode, or leaves the timer idle.

In frequency mode the channel-0 compare value acts as the counter's top value and channel 0 toggles every time the count meets it. The output frequency is therefore the clock divided by 2·N·(C0+1), where N is the prescale factor. In PWM mode a separate period input sets the top value. Each channel goes high when the count passes its compare value and drops again when the count wraps at the top. Every channel has an enable and an invert bit, and the live count is visible on a port.

Top module: `tcwave_gen`

## Requirements
- R1: After reset the count is 0 and every waveform output equals its invert bit.
- R2: The prescale select code maps 0,1,2,3,4,5,6 to divide factors 1,2,4,8,64,256,1024. In an active mode the count moves exactly once every N clock cycles.
- R3: Prescale select code 7 stops the counter; the count holds its value.
- R4: In frequency mode (mode code 01) the top value is the channel-0 compare value and the period input is ignored. The count runs 0..C0 and then wraps to 0.
- R5: In frequency mode channel 0 toggles on each prescaled tick at which the count equals C0, at the same edge as the wrap. Each level lasts N·(C0+1) cycles, so C0 = 0 with N = 1 toggles on every clock.
- R6: In frequency mode, channels 1 and up produce no waveform; they output their invert bit.
- R7: In PWM mode (mode code 10) the top value is the period input. The count steps by one from 0 to the top value and wraps to 0, so one period is top+1 ticks.
- R8: In PWM mode, when a channel is enabled and its invert bit is clear, its output is high exactly while count > Cx and count ≤ top. When Cx ≥ top the output stays low.
- R9: A channel whose enable bit is clear outputs its invert bit.
- R10: A set invert bit inverts that channel's output in every mode.
- R11: Mode codes 00 and 11 are idle. In an idle mode the count is forced to 0 and every waveform outputs its invert bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | 01 frequency, 10 PWM, 00/11 idle |
| presc_sel | input | 3 | Prescale select code |
| period | input | CW | Top value in PWM mode |
| cmp | input | NCH*CW | Compare values, channel i at bits [i*CW +: CW] |
| ch_en | input | NCH | Per-channel waveform enable |
| ch_inv | input | NCH | Per-channel output invert |
| wave_out | output | NCH | Channel waveforms |
| count | output | CW | Current counter value |

## Verification
The bench measures how long the count holds each value for every prescale code. A divider that was off by one, or had a swapped table entry, would show the wrong hold length. In frequency mode the period input is set below C0, so a design that still wrapped on the period input would never reach C0. The bench also checks that C0 = 0 gives a toggle on every cycle. In PWM mode every sample of each channel is compared with the count window. This covers compare values of 0, equal to top and above top, so a set or clear placed one tick off, or a set that won over the clear at top, shows up at once. Disabled, inverted and idle cases are checked at the outputs.

// File: rtl/tcwave_gen.sv
module tcwave_gen #(
  parameter int CW  = 16,
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic [2:0]       presc_sel,
  input  logic [CW-1:0]    period,
  input  logic [NCH*CW-1:0] cmp,
  input  logic [NCH-1:0]   ch_en,
  input  logic [NCH-1:0]   ch_inv,
  output logic [NCH-1:0]   wave_out,
  output logic [CW-1:0]    count
);
  localparam int DW = 10;

  logic [DW-1:0] div_q;
  logic [DW-1:0] mask;
  logic          tick;
  logic          freq_m, pwm_m, active;
  logic [CW-1:0] top;
  logic          at_top;
  logic [NCH-1:0] wg;

  assign freq_m = (mode_sel == 2'b01);
  assign pwm_m  = (mode_sel == 2'b10);
  assign active = freq_m | pwm_m;
  assign top    = freq_m ? cmp[CW-1:0] : period;
  assign at_top = (count >= top);

  always_comb begin
    case (presc_sel)
      3'd0:    mask = DW'(0);
      3'd1:    mask = DW'(1);
      3'd2:    mask = DW'(3);
      3'd3:    mask = DW'(7);
      3'd4:    mask = DW'(63);
      3'd5:    mask = DW'(255);
      default: mask = DW'(1023);
    endcase
  end

  assign tick = (presc_sel != 3'd7) && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      count <= '0;
    end else begin
      div_q <= div_q + 1'b1;
      if (!active)
        count <= '0;
      else if (tick)
        count <= at_top ? '0 : count + 1'b1;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CW-1:0] cv;
    assign cv = cmp[i*CW +: CW];
    always_ff @(posedge clk) begin
      if (!rst_n || !active) begin
        wg[i] <= 1'b0;
      end else if (tick) begin
        if (freq_m) begin
          if (i == 0 && at_top) wg[i] <= ~wg[i];
        end else begin
          if (at_top)          wg[i] <= 1'b0;
          else if (count == cv) wg[i] <= 1'b1;
        end
      end
    end
  end

  assign wave_out = ({NCH{active}} & ch_en & wg) ^ ch_inv;
endmodule

// File: rtl/tcwave_gen_chk.sv
module tcwave_gen_chk #(
  parameter int CW  = 16,
  parameter int NCH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_sel,
  input logic [CW-1:0]    period,
  input logic [NCH*CW-1:0] cmp,
  input logic [NCH-1:0]   ch_en,
  input logic [NCH-1:0]   ch_inv,
  input logic [NCH-1:0]   wave_out,
  input logic [CW-1:0]    count
);
  logic act, frq;
  logic [CW-1:0] topv;
  logic [NCH-1:0] raw;
  assign frq  = (mode_sel == 2'b01);
  assign act  = frq || (mode_sel == 2'b10);
  assign topv = frq ? cmp[CW-1:0] : period;
  assign raw  = wave_out ^ ch_inv;

  p_idle_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> (count == '0));

  p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act && $past(act) && count != $past(count)) |->
      (count == '0 || count == CW'($past(count) + 1'b1)));

  p_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act && $past(act) && $stable(topv) && $stable(mode_sel) && ($past(count) <= $past(topv)))
      |-> (count <= topv));

  p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw & ~ch_en) == '0));

  p_freq_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frq && $past(frq) && ch_en[0] && $past(ch_en[0]) && $stable(ch_inv[0])
      && wave_out[0] != $past(wave_out[0])) |-> (count == '0));

  p_freq_others_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frq |-> (raw[NCH-1:1] == '0));
endmodule

bind tcwave_gen tcwave_gen_chk #(.CW(CW), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .period(period), .cmp(cmp),
  .ch_en(ch_en), .ch_inv(ch_inv), .wave_out(wave_out), .count(count)
);

// File: tb/sim_tcwave_gen.sv
module sim_tcwave_gen;
  localparam int CLK_P = 10;
  localparam int CW = 16;
  localparam int NCH = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] mode_sel = 2'b00;
  logic [2:0] presc_sel = 3'd0;
  logic [CW-1:0] period = '0;
  logic [NCH*CW-1:0] cmp = '0;
  logic [NCH-1:0] ch_en = '0;
  logic [NCH-1:0] ch_inv = '0;
  logic [NCH-1:0] wave_out;
  logic [CW-1:0] count;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  tcwave_gen #(.CW(CW), .NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .presc_sel(presc_sel),
    .period(period), .cmp(cmp), .ch_en(ch_en), .ch_inv(ch_inv),
    .wave_out(wave_out), .count(count)
  );

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input logic [1:0] m, input logic [2:0] p, input logic [CW-1:0] per,
                       input logic [CW-1:0] c0, c1, c2, c3,
                       input logic [NCH-1:0] en, inv);
    @(negedge clk);
    mode_sel = 2'b00;
    @(negedge clk);
    presc_sel = p; period = per; cmp = {c3, c2, c1, c0}; ch_en = en; ch_inv = inv;
    @(negedge clk);
    mode_sel = m;
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 count", count == 0, count, 0);
    chk("R1 wave", wave_out == ch_inv, wave_out, ch_inv);
  endtask

  task automatic t_prescale();
    int fac [7] = '{1, 2, 4, 8, 64, 256, 1024};
    for (int s = 0; s < 7; s++) begin
      logic [CW-1:0] prev;
      int n;
      setup(2'b10, 3'(s), 16'hFFFF, 16'hFFFF, 0, 0, 0, '0, '0);
      prev = count;
      while (count == prev) @(negedge clk);
      prev = count; n = 0;
      while (count == prev) begin @(negedge clk); n++; end
      chk("R2 hold length", n == fac[s], n, fac[s]);
    end
  endtask

  task automatic t_halt();
    bit ok = 1;
    setup(2'b10, 3'd7, 16'd20, 0, 0, 0, 0, '0, '0);
    repeat (50) begin @(negedge clk); if (count != 0) ok = 0; end
    chk("R3 halted count", ok, count, 0);
  endtask

  task automatic t_freq_basic();
    int mx = 0; int n; logic w;
    setup(2'b01, 3'd0, 16'd2, 16'd3, 0, 0, 0, 4'b1111, '0);
    repeat (40) begin @(negedge clk); if (count > mx) mx = count; end
    chk("R4 max count is C0", mx == 3, mx, 3);
    w = wave_out[0];
    while (wave_out[0] == w) @(negedge clk);
    w = wave_out[0]; n = 0;
    while (wave_out[0] == w) begin @(negedge clk); n++; end
    chk("R5 half period N1 C3", n == 4, n, 4);
    chk("R6 other channels low", wave_out[3:1] == 3'b000, wave_out[3:1], 0);
  endtask

  task automatic t_freq_presc();
    int n; logic w;
    setup(2'b01, 3'd2, 16'd100, 16'd1, 0, 0, 0, 4'b0001, '0);
    w = wave_out[0];
    while (wave_out[0] == w) @(negedge clk);
    w = wave_out[0]; n = 0;
    while (wave_out[0] == w) begin @(negedge clk); n++; end
    chk("R5 half period N4 C1", n == 8, n, 8);
  endtask

  task automatic t_freq_max();
    bit ok = 1; logic w;
    setup(2'b01, 3'd0, 16'd50, 16'd0, 0, 0, 0, 4'b0001, 4'b1110);
    repeat (3) @(negedge clk);
    w = wave_out[0];
    repeat (10) begin @(negedge clk); if (wave_out[0] == w) ok = 0; w = wave_out[0]; end
    chk("R5 toggle every cycle", ok, ok, 1);
    chk("R6 others at invert", wave_out[3:1] == 3'b111, wave_out[3:1], 7);
  endtask

  task automatic t_pwm_window(input logic [NCH-1:0] inv);
    logic [CW-1:0] cv [4] = '{16'd3, 16'd0, 16'd9, 16'd12};
    bit ok [4] = '{1, 1, 1, 1};
    bit wrap_ok = 1; int mx = 0; logic [CW-1:0] prev;
    setup(2'b10, 3'd0, 16'd9, cv[0], cv[1], cv[2], cv[3], 4'b1111, inv);
    @(negedge clk);
    prev = count;
    repeat (35) begin
      @(negedge clk);
      if (count > mx) mx = count;
      if (!(count == prev + 1 || (prev == 9 && count == 0))) wrap_ok = 0;
      prev = count;
      for (int i = 0; i < 4; i++)
        if (wave_out[i] != ((count > cv[i] && count <= 9) ^ inv[i])) ok[i] = 0;
    end
    chk("R7 max count is period", mx == 9, mx, 9);
    chk("R7 step and wrap", wrap_ok, wrap_ok, 1);
    for (int i = 0; i < 4; i++)
      chk(inv == 0 ? "R8 pwm window" : "R10 inverted pwm", ok[i], i, 1);
  endtask

  task automatic t_disable();
    bit ok = 1;
    setup(2'b10, 3'd0, 16'd7, 16'd2, 16'd2, 16'd2, 16'd2, 4'b0101, 4'b1000);
    repeat (20) begin
      @(negedge clk);
      if (wave_out[1] != 1'b0 || wave_out[3] != 1'b1) ok = 0;
    end
    chk("R9 disabled channels", ok, wave_out, 4'b1000);
  endtask

  task automatic t_idle(input logic [1:0] m);
    bit ok = 1;
    setup(2'b10, 3'd0, 16'd7, 16'd1, 16'd1, 16'd1, 16'd1, 4'b1111, 4'b0110);
    repeat (5) @(negedge clk);
    mode_sel = m;
    @(negedge clk);
    repeat (10) begin
      @(negedge clk);
      if (count != 0 || wave_out != 4'b0110) ok = 0;
    end
    chk("R11 idle count and outputs", ok, count, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_prescale();
    t_halt();
    t_freq_basic();
    t_freq_presc();
    t_freq_max();
    t_pwm_window(4'b0000);
    t_pwm_window(4'b0101);
    t_disable();
    t_idle(2'b00);
    t_idle(2'b11);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule